// File: doc/BRIEF.md
# CAM Host Control Register Port

This block is the host-facing register interface of a small content-addressable memory. A host that runs on its own timing reaches four control registers through a select / acknowledge handshake. It presents a 3-bit address and a write-enable, plus write data when it writes. It raises select and holds every one of these signals until the block raises acknowledge. It then drops select, and the block drops acknowledge in turn. Select, write-enable and address pass through synchronisers before the internal clock domain uses them. Write data is taken only once the synchronised select has been seen, and the handshake keeps it stable until then.

The block holds four registers: a flag register, an error register, an interrupt mask and a 12-bit almost-full threshold. A synchronous soft reset input loads each register with its defined value, but only after the input has been sampled high on two consecutive rising edges. That reset event also sends a one-cycle clear pulse toward the match table and the pending-entry queue. An active-low asynchronous reset puts the whole block into the same register state, with no clear pulse.

Top module: `cam_ctrl_port`

## Requirements
- R1: After either reset, the registers read as follows: address 0 (flag) 0x001C, address 1 (error) 0xFFFF, address 2 (interrupt mask) 0x0000, address 3 (almost-full) 0x0FFF.
- R2: `sreset_i` changes the registers only when it is sampled high on two consecutive rising edges. A single sampled-high cycle leaves every register unchanged and produces no clear pulse.
- R3: Each qualifying soft-reset event drives `clear_o` high for exactly one cycle, starting after the second consecutive high sample. This holds even when `sreset_i` stays high longer.
- R4: The level of `we_i` while `sel_i` is high selects the transfer type: high means a read and low means a write.
- R5: `ack_o` rises at the fourth rising edge at which `sel_i` is sampled high.
- R6: `ack_o` stays high while `sel_i` is high. It falls at the third rising edge after `sel_i` is sampled low. No new transfer begins while `ack_o` is high.
- R7: `rdata_o` is zero except while `ack_o` is high during a read.
- R8: The almost-full register stores 12 bits. On a read, bits 15:12 are zero.
- R9: Addresses 4 to 7 map to no register. Writes to them are acknowledged and change nothing, and reads from them return zero.
- R10: A value written to addresses 0 to 2 is returned by a later read of the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sreset_i | input | 1 | Synchronous soft reset; must be high for two consecutive samples |
| sel_i | input | 1 | Host select strobe, asynchronous |
| we_i | input | 1 | Host write-enable: high means read, low means write |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, zero outside a read acknowledge |
| ack_o | output | 1 | Transfer acknowledge |
| clear_o | output | 1 | One-cycle clear pulse toward the table and the entry queue |

## Verification
The assertions rely on the host keeping its side of the handshake. The host holds select high until acknowledge rises and keeps it low until acknowledge falls. It also keeps address and write-enable constant across the whole acknowledge phase. The bench drives every transfer from a single task that waits on acknowledge in both directions and changes its inputs only on falling edges. Soft reset is applied only while no transfer is in flight.

// File: rtl/cam_ctrl_pkg.sv
package cam_ctrl_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int AF_W   = 12;

  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ERR   = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd2;
  localparam logic [ADDR_W-1:0] A_AFULL = 3'd3;

  localparam logic [DATA_W-1:0] FLAG_INIT  = 16'h001C;
  localparam logic [DATA_W-1:0] ERR_INIT   = 16'hFFFF;
  localparam logic [DATA_W-1:0] MASK_INIT  = 16'h0000;
  localparam logic [AF_W-1:0]   AFULL_INIT = 12'hFFF;

  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_ACCESS = 2'd1,
    HS_ACK    = 2'd2
  } hs_state_e;

  typedef struct packed {
    logic              sel;
    logic              we;
    logic [ADDR_W-1:0] addr;
  } host_ctl_t;
endpackage

// File: rtl/cam_sync.sv
module cam_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cam_hs_fsm.sv
module cam_hs_fsm
  import cam_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_s_i,
  output logic access_o,
  output logic ack_o
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE:   if (sel_s_i) state_d = HS_ACCESS;
      HS_ACCESS: state_d = HS_ACK;
      HS_ACK:    if (!sel_s_i) state_d = HS_IDLE;
      default:   state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_IDLE;
    else         state_q <= state_d;
  end

  assign access_o = (state_q == HS_ACCESS);
  assign ack_o    = (state_q == HS_ACK);
endmodule

// File: rtl/cam_rst_seq.sv
module cam_rst_seq #(
  parameter int HOLD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sreset_i,
  output logic init_o,
  output logic clear_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;
  logic          clear_q;

  // fire on the edge that sees the HOLD-th consecutive high sample
  assign init_o = sreset_i && (cnt_q == CW'(HOLD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      clear_q <= 1'b0;
    end else begin
      clear_q <= init_o;
      if (!sreset_i)                cnt_q <= '0;
      else if (cnt_q != CW'(HOLD))  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clear_o = clear_q;
endmodule

// File: rtl/cam_reg_file.sv
module cam_reg_file
  import cam_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] flag_q, err_q, mask_q;
  logic [AF_W-1:0]   afull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= FLAG_INIT;
      err_q   <= ERR_INIT;
      mask_q  <= MASK_INIT;
      afull_q <= AFULL_INIT;
    end else if (init_i) begin
      flag_q  <= FLAG_INIT;
      err_q   <= ERR_INIT;
      mask_q  <= MASK_INIT;
      afull_q <= AFULL_INIT;
    end else if (wr_en_i) begin
      case (addr_i)
        A_FLAG:  flag_q  <= wdata_i;
        A_ERR:   err_q   <= wdata_i;
        A_MASK:  mask_q  <= wdata_i;
        A_AFULL: afull_q <= wdata_i[AF_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_FLAG:  rdata_o = flag_q;
      A_ERR:   rdata_o = err_q;
      A_MASK:  rdata_o = mask_q;
      A_AFULL: rdata_o = {{(DATA_W-AF_W){1'b0}}, afull_q};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cam_ctrl_port.sv
module cam_ctrl_port
  import cam_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_HOLD    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sreset_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  output logic              clear_o
);
  localparam int CTL_W = $bits(host_ctl_t);

  host_ctl_t         ctl_raw, ctl_s;
  logic              access, init, wr_en, rd_q;
  logic [DATA_W-1:0] rf_rdata, rdata_q;

  assign ctl_raw = '{sel: sel_i, we: we_i, addr: addr_i};

  cam_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  cam_hs_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_s_i (ctl_s.sel),
    .access_o(access),
    .ack_o   (ack_o)
  );

  cam_rst_seq #(.HOLD(RST_HOLD)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sreset_i(sreset_i),
    .init_o  (init),
    .clear_o (clear_o)
  );

  // wdata_i is held by the handshake, so sampling it once sel is synced is safe
  assign wr_en = access && !ctl_s.we;

  cam_reg_file u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init),
    .wr_en_i(wr_en),
    .addr_i (ctl_s.addr),
    .wdata_i(wdata_i),
    .rdata_o(rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      rdata_q <= '0;
    end else if (access) begin
      rd_q    <= ctl_s.we;
      rdata_q <= ctl_s.we ? rf_rdata : '0;
    end
  end

  assign rdata_o = (ack_o && rd_q) ? rdata_q : '0;
endmodule

// File: rtl/cam_ctrl_port_chk.sv
module cam_ctrl_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sreset_i,
  input logic        sel_i,
  input logic        we_i,
  input logic [2:0]  addr_i,
  input logic [15:0] rdata_o,
  input logic        ack_o,
  input logic        clear_o
);
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> !clear_o); // R3

  AST_CLEAR_NEEDS_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clear_o) |-> $past(sreset_i) && $past(sreset_i, 2)); // R2

  AST_ACK_RISE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(sel_i) && $past(sel_i, 2) && $past(sel_i, 3)); // R5

  AST_ACK_FALL_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> !$past(sel_i) && !$past(sel_i, 2)); // R6

  AST_RDATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> rdata_o == 16'h0); // R7

  AST_RDATA_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && !we_i |-> rdata_o == 16'h0); // R4

  AST_AFULL_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && addr_i == 3'd3 |-> rdata_o[15:12] == 4'h0); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && addr_i[2] |-> rdata_o == 16'h0); // R9
endmodule

bind cam_ctrl_port cam_ctrl_port_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sreset_i(sreset_i),
  .sel_i   (sel_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .ack_o   (ack_o),
  .clear_o (clear_o)
);

// File: tb/cam_ctrl_port_bench.sv
module cam_ctrl_port_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sreset_i = 1'b0;
  logic        sel_i = 1'b0;
  logic        we_i = 1'b1;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        ack_o, clear_o;

  int checks = 0, fails = 0, clr_seen = 0;
  bit done = 0;
  int mdl [8];
  int rst_run = 0;
  bit exp_clear = 0;

  cam_ctrl_port u_cam_ctrl_port (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void mdl_init();
    mdl[0] = 'h001C; mdl[1] = 'hFFFF; mdl[2] = 0; mdl[3] = 'h0FFF;
    for (int i = 4; i < 8; i++) mdl[i] = 0;
  endfunction

  // reference model: soft reset counter and clear pulse
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_run = 0; exp_clear = 0; mdl_init();
    end else begin
      exp_clear = 0;
      if (sreset_i) begin
        rst_run++;
        if (rst_run == 2) begin mdl_init(); exp_clear = 1; end
      end else rst_run = 0;
    end
  end

  // per-clock comparison
  always @(negedge clk_i) if (rst_ni && !done) begin
    chk("R3 clear_o", clear_o, exp_clear);
    if (clear_o) clr_seen++;
    if (!ack_o) chk("R7 rdata_o idle", rdata_o, 0);
  end

  task automatic xfer(input bit wr, input logic [2:0] a, input logic [15:0] d, output logic [15:0] rd);
    int n;
    @(negedge clk_i);
    sel_i = 1; we_i = !wr; addr_i = a; wdata_i = d;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk_i); @(negedge clk_i); n++;
      if (ack_o) break;
    end
    chk("R5 ack rise edges", n, 4);
    rd = rdata_o;
    if (wr) chk("R4 rdata on write", rdata_o, 0);
    sel_i = 0;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk_i); @(negedge clk_i); n++;
      if (!ack_o) break;
    end
    chk("R6 ack fall edges", n, 3);
    we_i = 1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    logic [15:0] r;
    xfer(1, a, d, r);
    if (a == 3) mdl[3] = d & 16'h0FFF;
    else if (a < 3) mdl[a] = d;
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    logic [15:0] r;
    xfer(0, a, 16'h0, r);
    chk(req, r, mdl[a]);
  endtask

  task automatic pulse_sreset(input int cyc);
    @(negedge clk_i); sreset_i = 1;
    repeat (cyc) @(negedge clk_i);
    sreset_i = 0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 ack after reset", ack_o, 0);
    chk("R3 clear after reset", clear_o, 0);
    for (int a = 0; a < 4; a++) rd(3'(a), "R1 reset value");

    wr(0, 16'h1234); wr(1, 16'hA5A5); wr(2, 16'h00FF); wr(3, 16'hFFFF);
    for (int a = 0; a < 3; a++) rd(3'(a), "R10 readback");
    rd(3, "R8 afull 12-bit");
    wr(3, 16'h7ABC); rd(3, "R8 afull upper zero");

    wr(5, 16'hBEEF); wr(7, 16'h1111);
    rd(5, "R9 unmapped read"); rd(7, "R9 unmapped read");
    for (int a = 0; a < 4; a++) rd(3'(a), "R9 regs untouched");

    c0 = clr_seen;
    pulse_sreset(1);
    chk("R2 single sample no pulse", clr_seen - c0, 0);
    for (int a = 0; a < 4; a++) rd(3'(a), "R2 single sample no effect");

    c0 = clr_seen;
    pulse_sreset(2);
    chk("R3 two samples one pulse", clr_seen - c0, 1);
    for (int a = 0; a < 4; a++) rd(3'(a), "R1 soft reset value");

    wr(2, 16'hC3C3); wr(0, 16'h0001);
    c0 = clr_seen;
    pulse_sreset(6);
    chk("R3 long hold one pulse", clr_seen - c0, 1);
    rd(2, "R1 mask cleared"); rd(0, "R1 flag reloaded");

    wr(1, 16'h0000); rd(1, "R4 write then read");
    wr(1, 16'h8001); rd(1, "R4 write then read");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule